// File: doc/BRIEF.md
# LED Matrix Frame Serializer

This block reads a 32-row by 128-column monochrome frame from a pixel-row store and sends it to a display controller. The controller sees the panel as 64 logical rows of 64 bits. Each physical row is folded into two logical rows: first its left half, then its right half. Each logical row goes out as a 64-bit serial burst on a data line with its own shift clock. A latch pulse commits each burst.

One start strobe sends one whole frame: 64 bursts, each followed by its own latch. When the last burst has been latched, the block raises a one-cycle done pulse. The row store is read through a plain address/data port. The block holds the address steady while a row is in use.

Top module: `matrix_frame_tx`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. In the cycle after a reset edge, `latch`, `shiftClk`, `serData` and `done` are all low.
- R2: Logical row k (0 to 63) reads physical row k>>1 through `rowAddr`. Even k sends `rowData[127:64]` (the left half, column 0 at bit 127). Odd k sends `rowData[63:0]` (the right half).
- R3: Each burst has exactly 64 rising edges of `shiftClk` while `latch` is high. Bits go out most significant first, so a receiver that shifts left holds the leftmost pixel in its MSB. When `latch` falls, `serData` is low.
- R4: `shiftClk` has a period of `DIV` system clocks. `serData` changes only while `shiftClk` is low and is stable while it is high.
- R5: `latch` stays high for the whole burst. Between bursts it is low for exactly `GAP_PERIODS*DIV+1` system clocks, with no `shiftClk` rising edge during that time.
- R6: A frame is exactly 64 bursts, followed by a single-cycle `done` pulse. With start sampled at edge 0, `done` is high in cycle 64*(1+64*DIV+GAP_PERIODS*DIV)+1.
- R7: A `start` pulse while a frame is in progress is ignored. The frame keeps its timing and content, and no extra burst follows it.
- R8: After `start` is sampled, `latch` is low for one cycle (the row fetch) and rises in the second cycle.
- R9: `rowAddr` is stable for as long as `latch` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a frame when idle |
| rowAddr | output | 5 | Physical row index to the row store |
| rowData | input | 128 | Pixel row for `rowAddr`, valid in the cycle after the address changes |
| serData | output | 1 | Serial pixel data |
| shiftClk | output | 1 | Shift clock for `serData` |
| latch | output | 1 | High while a burst is shifted; falling edge commits it |
| done | output | 1 | One-cycle pulse after the 64th burst |

## Verification
The bench samples every output on the falling edge of the system clock, half a cycle after the registers settle. It counts cycles from the edge that samples `start`:
- In cycle 1, `latch` must still be low (the fetch cycle).
- In cycle 2, `latch` must be high.
- `done` must appear in exactly cycle 64*(1+64*DIV+GAP_PERIODS*DIV)+1 and be gone one cycle later.

A receiver model inside the bench shifts on each sampled rising edge of `shiftClk`. It compares each committed burst with the expected half row at the falling edge of `latch`. It also times the clock period and the low gap between bursts in whole cycles.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_GAP,
    ST_FIN
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a half row into the shifter
    logic shift;      // advance the shifter by one bit
    logic rightHalf;  // select the low half of the row word
  } dpStrobe_t;
endpackage

// File: rtl/mfs_ctrl.sv
module mfs_ctrl
  import mfs_pkg::*;
#(
  parameter int DIV          = 4,
  parameter int GAP_PERIODS  = 2,
  parameter int LOGICAL_ROWS = 64,
  parameter int CHUNK_BITS   = 64,
  parameter int ADDR_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] rowAddr,
  output logic              latch,
  output logic              shiftClk,
  output logic              done
);
  localparam int PH_W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LOW_LEN = DIV - DIV / 2;
  localparam int GAP_CYC = GAP_PERIODS * DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int BIT_W   = $clog2(CHUNK_BITS);
  localparam int CHUNK_W = $clog2(LOGICAL_ROWS);

  ctrlState_t         state;
  logic [PH_W-1:0]    phase;
  logic [BIT_W-1:0]   bitCnt;
  logic [CHUNK_W-1:0] chunkCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic lastPhase, lastBit, lastGap, lastChunk;

  assign lastPhase = (phase == PH_W'(DIV - 1));
  assign lastBit   = (bitCnt == BIT_W'(CHUNK_BITS - 1));
  assign lastGap   = (gapCnt == GAP_W'(GAP_CYC - 1));
  assign lastChunk = (chunkCnt == CHUNK_W'(LOGICAL_ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitCnt   <= '0;
      chunkCnt <= '0;
      gapCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_FETCH;
          chunkCnt <= '0;
        end
        ST_FETCH: begin
          state  <= ST_SHIFT;
          phase  <= '0;
          bitCnt <= '0;
        end
        ST_SHIFT: begin
          if (lastPhase) begin
            phase <= '0;
            if (lastBit) begin
              state  <= ST_GAP;
              gapCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_GAP: begin
          if (lastGap) begin
            if (lastChunk) begin
              state <= ST_FIN;
            end else begin
              chunkCnt <= chunkCnt + 1'b1;
              state    <= ST_FETCH;
            end
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load      = (state == ST_FETCH);
    strobe.shift     = (state == ST_SHIFT) && lastPhase;
    strobe.rightHalf = chunkCnt[0];
  end

  assign rowAddr  = ADDR_W'(chunkCnt >> 1);
  assign latch    = (state == ST_SHIFT);
  assign shiftClk = latch && (phase >= PH_W'(LOW_LEN));
  assign done     = (state == ST_FIN);
endmodule

// File: rtl/mfs_datapath.sv
module mfs_datapath
  import mfs_pkg::*;
#(
  parameter int CHUNK_BITS = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpStrobe_t               strobe,
  input  logic [2*CHUNK_BITS-1:0] rowData,
  output logic                    serData
);
  logic [CHUNK_BITS-1:0] shiftReg;
  logic [CHUNK_BITS-1:0] halfSel;

  assign halfSel = strobe.rightHalf ? rowData[CHUNK_BITS-1:0]
                                    : rowData[2*CHUNK_BITS-1:CHUNK_BITS];

  always_ff @(posedge clk) begin
    if (rst)
      shiftReg <= '0;
    else if (strobe.load)
      shiftReg <= halfSel;
    else if (strobe.shift)
      shiftReg <= {shiftReg[CHUNK_BITS-2:0], 1'b0};
  end

  assign serData = shiftReg[CHUNK_BITS-1];
endmodule

// File: rtl/matrix_frame_tx.sv
module matrix_frame_tx
  import mfs_pkg::*;
#(
  parameter int ROWS        = 32,
  parameter int COLS        = 128,
  parameter int DIV         = 4,
  parameter int GAP_PERIODS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic [$clog2(ROWS)-1:0]  rowAddr,
  input  logic [COLS-1:0]          rowData,
  output logic                     serData,
  output logic                     shiftClk,
  output logic                     latch,
  output logic                     done
);
  localparam int CHUNK_BITS   = COLS / 2;
  localparam int LOGICAL_ROWS = 2 * ROWS;
  localparam int ADDR_W       = $clog2(ROWS);

  dpStrobe_t strobe;

  mfs_ctrl #(
    .DIV(DIV), .GAP_PERIODS(GAP_PERIODS), .LOGICAL_ROWS(LOGICAL_ROWS),
    .CHUNK_BITS(CHUNK_BITS), .ADDR_W(ADDR_W)
  ) ctrl (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe),
    .rowAddr(rowAddr), .latch(latch), .shiftClk(shiftClk), .done(done)
  );

  mfs_datapath #(.CHUNK_BITS(CHUNK_BITS)) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rowData(rowData), .serData(serData)
  );
endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rowAddr,
  input logic              serData,
  input logic              shiftClk,
  input logic              latch,
  input logic              done
);
  logic rstQ;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: outputs idle in the cycle after a reset edge
  always @(negedge clk)
    if (rstQ)
      a_r1_reset_idle: assert (!latch && !shiftClk && !serData && !done);

  // R4: data holds while the shift clock is high
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    (shiftClk && $past(shiftClk)) |-> $stable(serData));

  // R9: row address held for the whole burst
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (latch && $past(latch)) |-> $stable(rowAddr));

  // R3: every bit has been shifted out when the burst commits
  a_r3_drained_at_commit: assert property (@(posedge clk) disable iff (rst)
    $fell(latch) |-> !serData);

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind matrix_frame_tx mfs_checker #(.ADDR_W($clog2(ROWS))) chk (
  .clk(clk), .rst(rst), .rowAddr(rowAddr), .serData(serData),
  .shiftClk(shiftClk), .latch(latch), .done(done)
);

// File: tb/matrix_frame_tx_test.sv
`timescale 1ns/1ps
module matrix_frame_tx_test;
  localparam int ROWS = 32, COLS = 128, DIV = 4, GAP_PERIODS = 2;
  localparam int CB = COLS / 2;
  localparam int NCHUNK = 2 * ROWS;
  localparam int GAP_CYC = GAP_PERIODS * DIV;
  localparam int FRAME_CYC = NCHUNK * (1 + CB * DIV + GAP_CYC) + 1;
  localparam int WATCHDOG = 190000;
  // {mode, seed}: mode 0 fills every word with seed, mode 1 varies per row and word
  localparam logic [33:0] FRAMES [4] = '{
    {2'd0, 32'h0000_0000}, {2'd0, 32'hFFFF_FFFF},
    {2'd0, 32'hA5A5_5A5A}, {2'd1, 32'h1234_0F0F}
  };

  logic clk = 0, rst = 1, start = 0;
  logic [4:0] rowAddr;
  logic [COLS-1:0] rowData;
  logic serData, shiftClk, latch, done;
  logic [COLS-1:0] curFrame [ROWS];

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign rowData = curFrame[rowAddr];

  matrix_frame_tx #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .GAP_PERIODS(GAP_PERIODS)) uut (
    .clk(clk), .rst(rst), .start(start), .rowAddr(rowAddr), .rowData(rowData),
    .serData(serData), .shiftClk(shiftClk), .latch(latch), .done(done)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expChunk(int k);
    logic [COLS-1:0] r = curFrame[k >> 1];
    return (k % 2 == 0) ? r[COLS-1:CB] : r[CB-1:0];
  endfunction

  // Receiver model, sampled on the falling system-clock edge
  bit prevClk, prevLatch, prevData;
  logic [63:0] rxReg;
  int rxBits, rxChunk, lowCnt, sinceRise, doneCount, latchRises;
  int perViol, stabViol, gapViol, idleClkViol;

  always @(negedge clk) begin
    if (rst) begin
      prevClk = 0; prevLatch = 0; prevData = 0;
      rxBits = 0; rxChunk = 0; lowCnt = 0; sinceRise = 0;
    end else begin
      sinceRise++;
      if (shiftClk && !prevClk) begin
        if (!latch) idleClkViol++;
        if (rxBits > 0 && sinceRise != DIV) perViol++;
        sinceRise = 0;
        rxReg = {rxReg[62:0], serData};
        rxBits++;
      end
      if (shiftClk && prevClk && serData != prevData) stabViol++;
      if (latch && !prevLatch) begin
        latchRises++;
        if (rxChunk > 0 && lowCnt != GAP_CYC + 1) gapViol++;
        rxBits = 0;
      end
      if (prevLatch && !latch) begin
        check(rxBits == CB, "R3 bits per burst", 64'(rxBits), 64'(CB));
        // R2 R9: folded half row content, MSB first
        check(rxReg == expChunk(rxChunk), "R2 burst content", rxReg, expChunk(rxChunk));
        rxChunk++;
        lowCnt = 0;
      end
      if (!latch) lowCnt++;
      if (done) begin
        doneCount++;
        check(rxChunk == NCHUNK, "R6 bursts per frame", 64'(rxChunk), 64'(NCHUNK));
        rxChunk = 0;
      end
      prevClk = shiftClk; prevLatch = latch; prevData = serData;
    end
  end

  task automatic fillFrame(logic [1:0] mode, logic [31:0] seed);
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < 4; w++)
        curFrame[r][w*32 +: 32] = (mode == 0) ? seed
            : seed ^ (32'(r) * 32'h9E37_79B1) ^ (32'(w) * 32'h0100_0193);
  endtask

  task automatic runFrame(bit pulseMid);
    int cyc = 1;
    int d0 = doneCount;
    perViol = 0; stabViol = 0; gapViol = 0; idleClkViol = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(latch == 0, "R8 fetch cycle latch low", 64'(latch), 64'd0);
    @(negedge clk) cyc = 2;
    check(latch == 1, "R8 latch rises", 64'(latch), 64'd1);
    while (!done && cyc < FRAME_CYC + 50) begin
      @(negedge clk);
      cyc++;
      start = (pulseMid && (cyc == 5000 || cyc == 9001));
    end
    start = 0;
    check(cyc == FRAME_CYC, pulseMid ? "R7 latency kept" : "R6 done latency",
          64'(cyc), 64'(FRAME_CYC));
    @(negedge clk);
    check(done == 0, "R6 done one cycle", 64'(done), 64'd0);
    check(doneCount == d0 + 1, "R6 one done per frame", 64'(doneCount), 64'(d0 + 1));
    check(perViol == 0 && stabViol == 0, "R4 clock period and data stability",
          64'(perViol + stabViol), 64'd0);
    check(gapViol == 0 && idleClkViol == 0, "R5 gap length and no clock in gap",
          64'(gapViol + idleClkViol), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r0;
    fillFrame(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    check(!latch && !shiftClk && !serData && !done, "R1 reset state",
          {60'd0, latch, shiftClk, serData, done}, 64'd0);
    rst = 0;

    foreach (FRAMES[i]) begin
      fillFrame(FRAMES[i][33:32], FRAMES[i][31:0]);
      runFrame(0);
    end

    // R7: start pulses mid-frame are ignored; no extra burst afterwards
    fillFrame(2'd1, 32'hC0DE_7711);
    runFrame(1);
    r0 = latchRises;
    repeat (600) @(negedge clk);
    check(latchRises == r0, "R7 no burst after frame", 64'(latchRises), 64'(r0));

    // R1: reset mid-frame returns outputs to idle
    fillFrame(2'd1, 32'h5EED_0001);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (3001) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check(!latch && !shiftClk && !serData && !done, "R1 reset mid-frame",
          {60'd0, latch, shiftClk, serData, done}, 64'd0);
    rst = 0;
    r0 = latchRises;
    repeat (300) @(negedge clk);
    check(latchRises == r0 && !latch, "R1 stays idle after reset",
          64'(latchRises), 64'(r0));
    runFrame(0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule